// File: doc/BRIEF.md
# Odd-Parity After Double-Zero Detector

This block watches a serial bit stream, one bit per accepted clock edge, and raises its output when two conditions hold together: the number of ones accepted since reset is odd, and two zeros in a row have appeared somewhere in the accepted history. The second condition is sticky. Once a zero pair has been seen it stays met, and from then on the output simply follows the parity of the ones.

The block is a Moore machine with six states. The output comes from a register and is updated on the same edge that accepts a bit, so it never depends on the bit currently on the input. A sample-enable input decides which edges accept a bit. A synchronous reset returns the machine to its start state. The present state is driven onto a debug port with a fixed field encoding, so the internal conditions can be seen at the pins.

Top module: `odd_dz_top`

## Requirements
- R1: When `rst` is high at a rising edge, after that edge `state_dbg` is 3'b000 and `z` is 0, whatever `smp_en` and `din` are.
- R2: After every edge, `z` is 1 exactly when the ones accepted since reset are odd in number and a zero pair has been accepted. `z` is registered and does not change between edges.
- R3: Each accepted 1 toggles the parity bit `state_dbg[1]`. An accepted 0 leaves it unchanged.
- R4: Two zeros accepted on consecutive accepted edges set `state_dbg[2]`, even when the parity changed earlier. A 1 accepted between the two zeros prevents this. Once set, the bit stays set until reset.
- R5: At an edge where `smp_en` is low and `rst` is low, `state_dbg` and `z` keep their values.
- R6: `state_dbg` is {pair seen, odd parity, last accepted bit was 0}. Bit 0 is cleared once the pair is seen. Only the six codes 000, 001, 010, 011, 100 and 110 occur.
- R7: From reset, the accepted stream 1,1,0,0,1,1,0,1 gives `z` = 0,0,0,0,1,0,0,1 after the successive edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | When high, `din` is accepted at this edge |
| din | input | 1 | Serial data bit |
| z | output | 1 | Registered detector output |
| state_dbg | output | 3 | Present state {pair seen, odd, last zero} |

## Verification
The main function is driven with the fixed eight-bit stream, to confirm the output sequence given for it. Directed streams separate a true zero pair from zeros split by a single 1, and from a pair that arrives after an odd or an even number of ones. Long random streams with random enable gaps are compared on every edge against a reference that keeps a parity integer, a previous-zero flag and a sticky flag. The enable gaps show whether an idle edge is wrongly counted as a zero or as a break between two zeros. Resets issued in the middle of a stream confirm that the sticky flag and the parity both clear.

// File: rtl/odd_dz_pkg.sv
package odd_dz_pkg;

    localparam int unsigned ST_W = 3;

    // Encoding: {pair_seen, odd_parity, last_zero}
    typedef enum logic [ST_W-1:0] {
        ST_EVEN_IDLE = 3'b000,
        ST_EVEN_ZERO = 3'b001,
        ST_ODD_IDLE  = 3'b010,
        ST_ODD_ZERO  = 3'b011,
        ST_EVEN_DONE = 3'b100,
        ST_ODD_DONE  = 3'b110
    } dz_state_e;

    typedef struct packed {
        dz_state_e st;
        logic      z;
    } dz_regs_t;

endpackage

// File: rtl/odd_dz_next.sv
module odd_dz_next
    import odd_dz_pkg::*;
(
    input  dz_state_e cur,
    input  logic      bit_in,
    output dz_state_e nxt
);
    always_comb begin
        unique case (cur)
            ST_EVEN_IDLE: nxt = bit_in ? ST_ODD_IDLE  : ST_EVEN_ZERO;
            ST_EVEN_ZERO: nxt = bit_in ? ST_ODD_IDLE  : ST_EVEN_DONE;
            ST_ODD_IDLE:  nxt = bit_in ? ST_EVEN_IDLE : ST_ODD_ZERO;
            ST_ODD_ZERO:  nxt = bit_in ? ST_EVEN_IDLE : ST_ODD_DONE;
            ST_EVEN_DONE: nxt = bit_in ? ST_ODD_DONE  : ST_EVEN_DONE;
            ST_ODD_DONE:  nxt = bit_in ? ST_EVEN_DONE : ST_ODD_DONE;
            default:      nxt = ST_EVEN_IDLE;
        endcase
    end
endmodule

// File: rtl/odd_dz_outdec.sv
module odd_dz_outdec
    import odd_dz_pkg::*;
(
    input  dz_state_e st,
    output logic      z_val
);
    always_comb begin
        unique case (st)
            ST_ODD_DONE: z_val = 1'b1;
            default:     z_val = 1'b0;
        endcase
    end
endmodule

// File: rtl/odd_dz_top.sv
module odd_dz_top
    import odd_dz_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            smp_en,
    input  logic            din,
    output logic            z,
    output logic [ST_W-1:0] state_dbg
);
    dz_regs_t  regs_d, regs_q;
    dz_state_e step_st;
    dz_state_e sel_st;
    logic      z_dec;

    odd_dz_next u_next (
        .cur    (regs_q.st),
        .bit_in (din),
        .nxt    (step_st)
    );

    odd_dz_outdec u_dec (
        .st    (sel_st),
        .z_val (z_dec)
    );

    always_comb begin
        if (rst) begin
            sel_st = ST_EVEN_IDLE;
        end else if (smp_en) begin
            sel_st = step_st;
        end else begin
            sel_st = regs_q.st;
        end
        regs_d.st = sel_st;
        regs_d.z  = z_dec;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign z         = regs_q.z;
    assign state_dbg = regs_q.st;
endmodule

// File: rtl/odd_dz_chk.sv
module odd_dz_chk (
    input logic       clk,
    input logic       rst,
    input logic       smp_en,
    input logic       din,
    input logic       z,
    input logic [2:0] st
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (st == 3'b000) && !z);

    a_r2_z_follows_state: assert property (@(posedge clk) disable iff (rst)
        smp_en |=> (z == (st[2] && st[1])));

    a_r3_parity_toggle: assert property (@(posedge clk) disable iff (rst)
        (smp_en && din) |=> (st[1] != $past(st[1])));

    a_r4_pair_sets: assert property (@(posedge clk) disable iff (rst)
        (smp_en && !din && st[0]) |=> st[2]);

    a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
        st[2] |=> st[2]);

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !smp_en |=> ($stable(st) && $stable(z)));

    a_r6_legal_code: assert property (@(posedge clk) disable iff (rst)
        smp_en |=> !(st[2] && st[0]));
endmodule

bind odd_dz_top odd_dz_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .smp_en (smp_en),
    .din    (din),
    .z      (z),
    .st     (state_dbg)
);

// File: tb/test_odd_dz_top.sv
`timescale 1ns/1ps
module test_odd_dz_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_en = 1'b0;
    logic       din = 1'b0;
    logic       z;
    logic [2:0] state_dbg;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    int m_par   = 0;
    int m_prev0 = 0;
    int m_seen  = 0;

    always #10 clk = ~clk;

    odd_dz_top i_odd_dz_top (
        .clk(clk), .rst(rst), .smp_en(smp_en), .din(din),
        .z(z), .state_dbg(state_dbg)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_edge(input bit r, input bit e, input bit d);
        if (r) begin
            m_par = 0; m_prev0 = 0; m_seen = 0;
        end else if (e) begin
            if (d) begin
                m_par = 1 - m_par;
                m_prev0 = 0;
            end else begin
                if (m_prev0 == 1) m_seen = 1;
                m_prev0 = (m_seen == 1) ? 0 : 1;
            end
        end
    endtask

    task automatic step(input bit r, input bit e, input bit d, input string tag);
        int ez;
        int es;
        rst = r; smp_en = e; din = d;
        @(posedge clk);
        model_edge(r, e, d);
        @(negedge clk);
        ez = m_seen & m_par;
        es = m_seen * 4 + m_par * 2 + m_prev0;
        chk(z == ez[0], tag, int'(z), ez);
        chk(int'(state_dbg) == es, "R6", int'(state_dbg), es);
    endtask

    initial begin
        int seq [8] = '{1,1,0,0,1,1,0,1};
        int zexp [8] = '{0,0,0,0,1,0,0,1};
        @(negedge clk);
        // R1: reset state
        step(1, 0, 0, "R1");
        step(1, 1, 1, "R1");
        chk(state_dbg == 3'b000, "R1", int'(state_dbg), 0);

        // R7: fixed stream
        for (int i = 0; i < 8; i++) begin
            step(0, 1, seq[i][0], "R7");
            chk(z == zexp[i][0], "R7", int'(z), zexp[i]);
        end

        // R4: zeros split by a one are not a pair
        step(1, 0, 0, "R1");
        step(0, 1, 0, "R4"); step(0, 1, 1, "R4"); step(0, 1, 0, "R4");
        chk(state_dbg[2] == 1'b0, "R4", int'(state_dbg[2]), 0);
        step(0, 1, 0, "R4");
        chk(state_dbg[2] == 1'b1, "R4", int'(state_dbg[2]), 1);
        step(0, 1, 1, "R4"); step(0, 1, 1, "R4");
        chk(state_dbg[2] == 1'b1, "R4", int'(state_dbg[2]), 1);

        // R3: parity after pair, ones toggle z
        for (int i = 0; i < 5; i++) step(0, 1, 1, "R3");
        chk(z == 1'b0, "R3", int'(z), 0);

        // R5: enable low holds, even with din toggling
        step(0, 1, 1, "R5");
        for (int i = 0; i < 4; i++) step(0, 0, i[0], "R5");
        chk(z == 1'b1, "R5", int'(z), 1);

        // R5: idle edge between two zeros does not break the pair
        step(1, 0, 0, "R1");
        step(0, 1, 0, "R5"); step(0, 0, 1, "R5"); step(0, 1, 0, "R5");
        chk(state_dbg[2] == 1'b1, "R5", int'(state_dbg[2]), 1);

        // R2: random streams with random enable and occasional reset
        for (int i = 0; i < 3000; i++) begin
            bit r = ($urandom_range(0, 199) == 0);
            bit e = ($urandom_range(0, 3) != 0);
            bit d = ($urandom_range(0, 2) == 0);
            step(r, e, d, "R2");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule